// File: doc/BRIEF.md
# Triple-Redundant Fault Rollback Controller

This controller sits beside three identical processor cores that execute the same program in lockstep. Each core reports one record for every retired instruction. The record holds the program position, the destination register, the writeback value, and the address and data of its cache access. When all three records are present, the controller compares them. While they agree it tracks the last good position. When exactly one core disagrees with the other two, that core is marked faulty and a recovery sequence starts.

During recovery the controller first records where the faulty core was executing. It then copies the register file from a healthy core into the faulty one, one register per accepted transfer. Next it rewinds the faulty core to the last instruction on which all three agreed. It holds the healthy cores with a stall while the faulty core runs in catch-up mode. When the faulty core reaches the position where the fault was seen, the stall is released. The three cores must then agree on a run of consecutive records before normal comparison resumes. The length of that run grows by a fixed step after each completed recovery, up to a cap.

If all three records disagree, no majority exists. The controller raises a non-recoverable flag and halts until reset.

Top module: `tmr_rollback_ctrl`

## Requirements
- R1: During and immediately after reset, `fault_core` reads 3 (meaning no core), and `busy`, `fatal`, `stall_healthy`, `catchup_en`, `xfer_req`, `rewind_req` and `recov_cnt` are all 0.
- R2: Records are compared only when all three bits of `rec_valid` are 1. A partial set of valid records never starts a recovery, even if the data in them differ.
- R3: When exactly one core's record differs from the other two in any field (position, destination index, writeback data, cache address or cache data), the next cycle shows that core's index (0, 1 or 2) on `fault_core` and `busy` at 1.
- R4: From the cycle after detection, `fault_pc` holds the position that the faulty core reported in the disagreeing record.
- R5: The copy phase raises `xfer_req` with `xfer_idx` stepping up from 0 to NREG-1. The index advances only in a cycle with `xfer_ack` high. `xfer_dst` is the faulty core and `xfer_src` is the lowest-numbered healthy core.
- R6: In the cycle after the last acknowledged transfer, `rewind_req` is high for exactly one cycle. In that cycle `rewind_core` names the faulty core and `rewind_pc` equals the position of the most recent record on which all three cores agreed.
- R7: From the cycle after the rewind pulse, `stall_healthy` and `catchup_en` are high. They fall in the cycle after the faulty core presents a valid record whose position equals the healthy cores' position at detection.
- R8: After catch-up, `busy` stays high until the three cores have agreed on W consecutive compared records. W is WIN_BASE for the first recovery, grows by WIN_STEP after each completed recovery, and saturates at WIN_MAX.
- R9: When the confirmation run completes, `busy` falls, `fault_core` returns to 3, and `recov_cnt` increments, saturating at 2^CNT_W-1.
- R10: If all three records differ pairwise, `fatal` rises in the next cycle and stays high until reset. While `fatal` is high, `busy` is 0 and no register transfer is requested, even if the cores later agree.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rec_valid | input | 3 | Per-core record valid |
| rec_pc | input | 3x32 | Per-core program position of the retired instruction |
| rec_rd | input | 3x5 | Per-core destination register index |
| rec_wdata | input | 3x32 | Per-core register writeback value |
| rec_caddr | input | 3x32 | Per-core cache access address |
| rec_cdata | input | 3x32 | Per-core cache access data |
| xfer_ack | input | 1 | Register transfer accepted this cycle |
| xfer_req | output | 1 | Register transfer request |
| xfer_src | output | 2 | Core that supplies the register |
| xfer_dst | output | 2 | Core that receives the register |
| xfer_idx | output | $clog2(NREG) | Register being transferred |
| rewind_req | output | 1 | One-cycle rewind command to the faulty core |
| rewind_core | output | 2 | Core to rewind |
| rewind_pc | output | 32 | Position to restart from |
| stall_healthy | output | 1 | Hold the two healthy cores |
| catchup_en | output | 1 | Faulty core runs in accelerated catch-up mode |
| fault_core | output | 2 | Faulty core index, 3 when none |
| fault_pc | output | 32 | Position the faulty core reported at detection |
| busy | output | 1 | Recovery in progress |
| fatal | output | 1 | Non-recoverable fault, controller halted |
| recov_cnt | output | CNT_W | Saturating count of completed recoveries |

## Verification
The bench builds the block with NREG=4, CNT_W=2, WIN_BASE=2, WIN_STEP=1 and WIN_MAX=3. The short register file keeps each copy phase brief, so one test can run five full recoveries. Over those recoveries the confirmation window grows from two to three records and then stays at the cap. The 2-bit counter reaches its saturation value of 3 on the third recovery and holds it on the fourth and fifth. The runs place the fault on each core and corrupt a different record field each time. One run also withholds the transfer acknowledge for a cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int DATA_W = 32;
    localparam int RD_W   = 5;

    localparam logic [1:0] NO_CORE = 2'd3;

    typedef struct packed {
        logic [DATA_W-1:0] pc;
        logic [RD_W-1:0]   rd;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] caddr;
        logic [DATA_W-1:0] cdata;
    } core_rec_t;

    typedef enum logic [1:0] {
        VOTE_AGREE,
        VOTE_SINGLE,
        VOTE_NONE
    } vote_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_COMPARE,
        ST_LOCATE,
        ST_COPY,
        ST_REWIND,
        ST_CATCHUP,
        ST_RESYNC,
        ST_HALT
    } ctl_state_e;

endpackage

// File: rtl/tmr_voter.sv
module tmr_voter
    import tmr_pkg::*;
(
    input  core_rec_t [2:0] recs,
    output vote_e           verdict,
    output logic [1:0]      odd_core
);

    logic eq01, eq02, eq12;

    assign eq01 = (recs[0] == recs[1]);
    assign eq02 = (recs[0] == recs[2]);
    assign eq12 = (recs[1] == recs[2]);

    always_comb begin
        verdict  = VOTE_NONE;
        odd_core = NO_CORE;
        if (eq01 && eq02) begin
            verdict = VOTE_AGREE;
        end else if (eq12) begin
            verdict  = VOTE_SINGLE;
            odd_core = 2'd0;
        end else if (eq02) begin
            verdict  = VOTE_SINGLE;
            odd_core = 2'd1;
        end else if (eq01) begin
            verdict  = VOTE_SINGLE;
            odd_core = 2'd2;
        end
    end

endmodule

// File: rtl/tmr_copy_seq.sv
module tmr_copy_seq #(
    parameter int NREG = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic                    ack,
    output logic                    req,
    output logic [$clog2(NREG)-1:0] idx,
    output logic                    last
);

    localparam int IDX_W = $clog2(NREG);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NREG - 1);

    assign req  = en;
    assign last = en && ack && (idx == LAST_IDX);

    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            idx <= '0;
        end else if (ack && idx != LAST_IDX) begin
            idx <= idx + 1'b1;
        end
    end

endmodule

// File: rtl/tmr_resync_win.sv
module tmr_resync_win #(
    parameter int WIN_BASE = 2,
    parameter int WIN_STEP = 1,
    parameter int WIN_MAX  = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic agree,
    output logic confirmed
);

    localparam int WIN_W = $clog2(WIN_MAX + 1) + 1;
    localparam logic [WIN_W-1:0] W_BASE = WIN_W'(WIN_BASE);
    localparam logic [WIN_W-1:0] W_STEP = WIN_W'(WIN_STEP);
    localparam logic [WIN_W-1:0] W_MAX  = WIN_W'(WIN_MAX);

    logic [WIN_W-1:0] win_len;
    logic [WIN_W-1:0] run_cnt;

    assign confirmed = active && agree && (run_cnt == win_len - 1'b1);

    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            run_cnt <= '0;
        end else if (agree) begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_len <= W_BASE;
        end else if (confirmed) begin
            if (win_len + W_STEP >= W_MAX) begin
                win_len <= W_MAX;
            end else begin
                win_len <= win_len + W_STEP;
            end
        end
    end

endmodule

// File: rtl/tmr_rollback_ctrl.sv
module tmr_rollback_ctrl
    import tmr_pkg::*;
#(
    parameter int NREG     = 32,
    parameter int CNT_W    = 16,
    parameter int WIN_BASE = 2,
    parameter int WIN_STEP = 1,
    parameter int WIN_MAX  = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [2:0]                    rec_valid,
    input  logic [2:0][DATA_W-1:0]        rec_pc,
    input  logic [2:0][RD_W-1:0]          rec_rd,
    input  logic [2:0][DATA_W-1:0]        rec_wdata,
    input  logic [2:0][DATA_W-1:0]        rec_caddr,
    input  logic [2:0][DATA_W-1:0]        rec_cdata,
    input  logic                          xfer_ack,
    output logic                          xfer_req,
    output logic [1:0]                    xfer_src,
    output logic [1:0]                    xfer_dst,
    output logic [$clog2(NREG)-1:0]       xfer_idx,
    output logic                          rewind_req,
    output logic [1:0]                    rewind_core,
    output logic [DATA_W-1:0]             rewind_pc,
    output logic                          stall_healthy,
    output logic                          catchup_en,
    output logic [1:0]                    fault_core,
    output logic [DATA_W-1:0]             fault_pc,
    output logic                          busy,
    output logic                          fatal,
    output logic [CNT_W-1:0]              recov_cnt
);

    core_rec_t [2:0] recs;
    vote_e           verdict;
    logic [1:0]      odd_core;
    ctl_state_e      state, state_nx;

    logic              all_valid;
    logic              cmp_phase;
    logic              agree_now;
    logic              copy_last;
    logic              confirmed;
    logic              f_valid;
    logic [DATA_W-1:0] f_pc;
    logic              catch_hit;
    logic [DATA_W-1:0] target_pc;
    logic [DATA_W-1:0] last_good_pc;
    logic [DATA_W-1:0] healthy_pc;

    for (genvar g = 0; g < 3; g++) begin : g_rec
        assign recs[g] = {rec_pc[g], rec_rd[g], rec_wdata[g], rec_caddr[g], rec_cdata[g]};
    end

    tmr_voter u_voter (
        .recs     (recs),
        .verdict  (verdict),
        .odd_core (odd_core)
    );

    assign all_valid = &rec_valid;
    assign cmp_phase = (state == ST_COMPARE) || (state == ST_RESYNC);
    assign agree_now = all_valid && (verdict == VOTE_AGREE);

    tmr_copy_seq #(.NREG(NREG)) u_copy (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (state == ST_COPY),
        .ack   (xfer_ack),
        .req   (xfer_req),
        .idx   (xfer_idx),
        .last  (copy_last)
    );

    tmr_resync_win #(
        .WIN_BASE (WIN_BASE),
        .WIN_STEP (WIN_STEP),
        .WIN_MAX  (WIN_MAX)
    ) u_win (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (state == ST_RESYNC),
        .agree     (agree_now),
        .confirmed (confirmed)
    );

    // faulty core's live record and the healthy position at detection
    always_comb begin
        f_valid    = 1'b0;
        f_pc       = '0;
        healthy_pc = rec_pc[0];
        unique case (fault_core)
            2'd0:    begin f_valid = rec_valid[0]; f_pc = rec_pc[0]; end
            2'd1:    begin f_valid = rec_valid[1]; f_pc = rec_pc[1]; end
            2'd2:    begin f_valid = rec_valid[2]; f_pc = rec_pc[2]; end
            default: begin f_valid = 1'b0;         f_pc = '0;        end
        endcase
        if (odd_core == 2'd0) begin
            healthy_pc = rec_pc[1];
        end
    end

    assign catch_hit = f_valid && (f_pc == target_pc);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    state_nx = ST_COMPARE;
            ST_COMPARE,
            ST_RESYNC: begin
                if (all_valid) begin
                    unique case (verdict)
                        VOTE_AGREE:  if (state == ST_RESYNC && confirmed) state_nx = ST_COMPARE;
                        VOTE_SINGLE: state_nx = ST_LOCATE;
                        VOTE_NONE:   state_nx = ST_HALT;
                        default:     state_nx = ST_HALT;
                    endcase
                end
            end
            ST_LOCATE:  state_nx = ST_COPY;
            ST_COPY:    if (copy_last) state_nx = ST_REWIND;
            ST_REWIND:  state_nx = ST_CATCHUP;
            ST_CATCHUP: if (catch_hit) state_nx = ST_RESYNC;
            ST_HALT:    state_nx = ST_HALT;
            default:    state_nx = ST_HALT;
        endcase
    end

    always_comb begin
        busy          = 1'b0;
        fatal         = 1'b0;
        rewind_req    = 1'b0;
        stall_healthy = 1'b0;
        catchup_en    = 1'b0;
        unique case (state)
            ST_IDLE, ST_COMPARE:  ;
            ST_LOCATE, ST_COPY:   busy = 1'b1;
            ST_REWIND:            begin busy = 1'b1; rewind_req = 1'b1; end
            ST_CATCHUP:           begin busy = 1'b1; stall_healthy = 1'b1; catchup_en = 1'b1; end
            ST_RESYNC:            busy = 1'b1;
            ST_HALT:              fatal = 1'b1;
            default:              fatal = 1'b1;
        endcase
    end

    assign xfer_dst    = fault_core;
    assign xfer_src    = (fault_core == 2'd0) ? 2'd1 : 2'd0;
    assign rewind_core = fault_core;
    assign rewind_pc   = last_good_pc;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_core   <= NO_CORE;
            fault_pc     <= '0;
            target_pc    <= '0;
            last_good_pc <= '0;
            recov_cnt    <= '0;
        end else if (cmp_phase && all_valid) begin
            if (verdict == VOTE_AGREE) begin
                last_good_pc <= rec_pc[0];
                if (confirmed) begin
                    fault_core <= NO_CORE;
                    if (recov_cnt != '1) begin
                        recov_cnt <= recov_cnt + 1'b1;
                    end
                end
            end else if (verdict == VOTE_SINGLE) begin
                fault_core <= odd_core;
                fault_pc   <= rec_pc[odd_core];
                target_pc  <= healthy_pc;
            end
        end
    end

endmodule

// File: rtl/tmr_rollback_chk.sv
module tmr_rollback_chk #(
    parameter int NREG  = 32,
    parameter int CNT_W = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [2:0]              rec_valid,
    input logic [2:0][31:0]        rec_pc,
    input logic [31:0]             target_pc,
    input logic                    xfer_req,
    input logic                    xfer_ack,
    input logic [$clog2(NREG)-1:0] xfer_idx,
    input logic                    rewind_req,
    input logic                    stall_healthy,
    input logic [1:0]              fault_core,
    input logic                    busy,
    input logic                    fatal,
    input logic [CNT_W-1:0]        recov_cnt
);

    logic        f_valid;
    logic [31:0] f_pc;

    always_comb begin
        f_valid = 1'b0;
        f_pc    = '0;
        if (fault_core == 2'd0) begin f_valid = rec_valid[0]; f_pc = rec_pc[0]; end
        if (fault_core == 2'd1) begin f_valid = rec_valid[1]; f_pc = rec_pc[1]; end
        if (fault_core == 2'd2) begin f_valid = rec_valid[2]; f_pc = rec_pc[2]; end
    end

    // R3
    busy_has_core_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> fault_core != 2'd3);

    // R5
    xfer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && !xfer_ack) |=> (xfer_req && $stable(xfer_idx)));

    // R6
    rewind_then_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rewind_req |=> (stall_healthy && !rewind_req));

    // R7
    stall_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_healthy && f_valid && f_pc == target_pc) |=> !stall_healthy);

    // R9
    cnt_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> recov_cnt >= $past(recov_cnt));

    // R10
    fatal_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fatal |=> (fatal && !busy && !xfer_req));

endmodule

bind tmr_rollback_ctrl tmr_rollback_chk #(.NREG(NREG), .CNT_W(CNT_W)) u_rollback_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .rec_valid     (rec_valid),
    .rec_pc        (rec_pc),
    .target_pc     (target_pc),
    .xfer_req      (xfer_req),
    .xfer_ack      (xfer_ack),
    .xfer_idx      (xfer_idx),
    .rewind_req    (rewind_req),
    .stall_healthy (stall_healthy),
    .fault_core    (fault_core),
    .busy          (busy),
    .fatal         (fatal),
    .recov_cnt     (recov_cnt)
);

// File: tb/test_tmr_rollback_ctrl.sv
module test_tmr_rollback_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int NREG       = 4;
    localparam int CNT_W      = 2;
    localparam int WIN_BASE   = 2;
    localparam int WIN_STEP   = 1;
    localparam int WIN_MAX    = 3;
    localparam int IDX_W      = $clog2(NREG);

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic [2:0]            rec_valid = '0;
    logic [2:0][31:0]      rec_pc = '0;
    logic [2:0][4:0]       rec_rd = '0;
    logic [2:0][31:0]      rec_wdata = '0;
    logic [2:0][31:0]      rec_caddr = '0;
    logic [2:0][31:0]      rec_cdata = '0;
    logic                  xfer_ack = 1'b0;
    logic                  xfer_req;
    logic [1:0]            xfer_src, xfer_dst;
    logic [IDX_W-1:0]      xfer_idx;
    logic                  rewind_req;
    logic [1:0]            rewind_core;
    logic [31:0]           rewind_pc;
    logic                  stall_healthy, catchup_en;
    logic [1:0]            fault_core;
    logic [31:0]           fault_pc;
    logic                  busy, fatal;
    logic [CNT_W-1:0]      recov_cnt;

    int checks = 0;
    int errors = 0;
    logic [31:0] last_good = '0;
    int exp_cnt = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_rollback_ctrl #(
        .NREG(NREG), .CNT_W(CNT_W), .WIN_BASE(WIN_BASE),
        .WIN_STEP(WIN_STEP), .WIN_MAX(WIN_MAX)
    ) i_tmr_rollback_ctrl (
        .clk(clk), .rst_n(rst_n), .rec_valid(rec_valid), .rec_pc(rec_pc),
        .rec_rd(rec_rd), .rec_wdata(rec_wdata), .rec_caddr(rec_caddr),
        .rec_cdata(rec_cdata), .xfer_ack(xfer_ack), .xfer_req(xfer_req),
        .xfer_src(xfer_src), .xfer_dst(xfer_dst), .xfer_idx(xfer_idx),
        .rewind_req(rewind_req), .rewind_core(rewind_core), .rewind_pc(rewind_pc),
        .stall_healthy(stall_healthy), .catchup_en(catchup_en),
        .fault_core(fault_core), .fault_pc(fault_pc), .busy(busy),
        .fatal(fatal), .recov_cnt(recov_cnt)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_all(input logic [31:0] pc);
        for (int i = 0; i < 3; i++) begin
            rec_pc[i]    = pc;
            rec_rd[i]    = pc[6:2];
            rec_wdata[i] = pc ^ 32'h5a5a_0000;
            rec_caddr[i] = pc + 32'h1000;
            rec_cdata[i] = ~pc;
        end
        rec_valid = 3'b111;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        tick(); tick();
        chk("R1 fault_core", 32'(fault_core), 32'd3);
        chk("R1 busy", 32'(busy), 32'd0);
        chk("R1 fatal", 32'(fatal), 32'd0);
        chk("R1 stall", 32'(stall_healthy), 32'd0);
        chk("R1 xfer_req", 32'(xfer_req), 32'd0);
        chk("R1 recov_cnt", 32'(recov_cnt), 32'd0);
        rst_n = 1'b1;
        tick();
        chk("R1 after release busy", 32'(busy), 32'd0);
    endtask

    task automatic t_agree();
        set_all(32'h100);
        tick();
        last_good = 32'h100;
        chk("R2 agree busy", 32'(busy), 32'd0);
        chk("R2 agree fault_core", 32'(fault_core), 32'd3);
        set_all(32'h104);
        rec_wdata[2] = 32'hdead_beef;
        rec_valid = 3'b011;
        tick();
        chk("R2 partial busy", 32'(busy), 32'd0);
        tick();
        chk("R2 partial fault_core", 32'(fault_core), 32'd3);
        set_all(32'h104);
        tick();
        last_good = 32'h104;
        rec_valid = '0;
        tick();
        chk("R2 after agree busy", 32'(busy), 32'd0);
    endtask

    task automatic t_recover(input int b, input int field, input int win, input bit gap);
        logic [31:0] pc;
        logic [31:0] bad_pc;
        pc = last_good + 4;
        set_all(pc);
        bad_pc = pc;
        case (field)
            0: begin rec_pc[b] = pc ^ 32'h10; bad_pc = pc ^ 32'h10; end
            1: rec_rd[b] = rec_rd[b] ^ 5'h1;
            2: rec_wdata[b] = rec_wdata[b] ^ 32'h8;
            3: rec_caddr[b] = rec_caddr[b] ^ 32'h40;
            default: rec_cdata[b] = rec_cdata[b] ^ 32'h1;
        endcase
        tick();
        rec_valid = '0;
        chk("R3 fault_core", 32'(fault_core), 32'(b));
        chk("R3 busy", 32'(busy), 32'd1);
        chk("R4 fault_pc", fault_pc, bad_pc);
        tick();
        for (int i = 0; i < NREG; i++) begin
            if (gap && i == 1) begin
                xfer_ack = 1'b0;
                tick();
                chk("R5 idx held without ack", 32'(xfer_idx), 32'd1);
                chk("R5 req held without ack", 32'(xfer_req), 32'd1);
            end
            xfer_ack = 1'b1;
            chk("R5 xfer_req", 32'(xfer_req), 32'd1);
            chk("R5 xfer_idx", 32'(xfer_idx), 32'(i));
            chk("R5 xfer_dst", 32'(xfer_dst), 32'(b));
            chk("R5 xfer_src", 32'(xfer_src), (b == 0) ? 32'd1 : 32'd0);
            tick();
        end
        xfer_ack = 1'b0;
        chk("R6 rewind_req", 32'(rewind_req), 32'd1);
        chk("R6 rewind_core", 32'(rewind_core), 32'(b));
        chk("R6 rewind_pc", rewind_pc, last_good);
        chk("R5 copy ended", 32'(xfer_req), 32'd0);
        tick();
        chk("R6 rewind single cycle", 32'(rewind_req), 32'd0);
        chk("R7 stall", 32'(stall_healthy), 32'd1);
        chk("R7 catchup_en", 32'(catchup_en), 32'd1);
        rec_valid = '0;
        rec_valid[b] = 1'b1;
        rec_pc[b] = last_good;
        tick();
        chk("R7 stall before match", 32'(stall_healthy), 32'd1);
        rec_pc[b] = pc;
        tick();
        rec_valid = '0;
        chk("R7 stall released", 32'(stall_healthy), 32'd0);
        chk("R7 catchup released", 32'(catchup_en), 32'd0);
        chk("R8 busy in resync", 32'(busy), 32'd1);
        tick();
        chk("R8 idle cycle keeps busy", 32'(busy), 32'd1);
        for (int k = 0; k < win; k++) begin
            pc = pc + 4;
            set_all(pc);
            tick();
            last_good = pc;
            rec_valid = '0;
            if (k < win - 1) begin
                chk("R8 window not yet met", 32'(busy), 32'd1);
            end else begin
                if (exp_cnt < (1 << CNT_W) - 1) exp_cnt++;
                chk("R8 window met busy", 32'(busy), 32'd0);
                chk("R9 fault_core cleared", 32'(fault_core), 32'd3);
                chk("R9 recov_cnt", 32'(recov_cnt), 32'(exp_cnt));
            end
        end
    endtask

    task automatic t_fatal();
        set_all(last_good + 4);
        rec_wdata[0] = 32'h1111_1111;
        rec_caddr[1] = 32'h2222_2222;
        tick();
        chk("R10 fatal", 32'(fatal), 32'd1);
        chk("R10 busy", 32'(busy), 32'd0);
        set_all(last_good + 8);
        tick();
        chk("R10 fatal sticky", 32'(fatal), 32'd1);
        chk("R10 no transfer", 32'(xfer_req), 32'd0);
        chk("R10 no busy", 32'(busy), 32'd0);
        rec_valid = '0;
        t_reset();
        chk("R10 cleared by reset", 32'(fatal), 32'd0);
    endtask

    initial begin
        t_reset();
        t_agree();
        t_recover(1, 2, 2, 1'b1);
        t_recover(2, 0, 3, 1'b0);
        t_recover(0, 4, 3, 1'b0);
        t_recover(1, 1, 3, 1'b0);
        t_recover(2, 3, 3, 1'b0);
        t_fatal();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule